// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is the control port of an audio front end. A host writes it over three wires: a serial clock, a serial data line and a strobe. The port cannot be read back. Each write frame carries a 5-bit register address followed by a 5-bit data word, both sent most significant bit first. When the strobe goes low, the frame is stored in the addressed register. The register contents are decoded into the control outputs: gain codes, switch enables, parallel output bits and per-switch mute levels.

All three serial inputs are sampled in the system clock domain through two-stage synchronizers. A small state machine has three states:
- `ST_ARMED`: strobe high, waiting for it to fall.
- `ST_COMMIT`: a one-cycle write pulse to the register bank.
- `ST_HOLD`: waits for the strobe to return high.

The transitions are:
- `ST_ARMED` to `ST_COMMIT` on a synchronized strobe fall.
- `ST_COMMIT` to `ST_HOLD` always.
- `ST_HOLD` to `ST_ARMED` once the synchronized strobe reads high.
- Reset enters `ST_HOLD`.

A power-down input leaves the registers untouched, and writes are still taken while it is high.

Top module: `serial_cfg_bank`

## Requirements
- R1: The stored frame is the last 10 bits sampled on rising edges of `sclk`. The first 5 of those bits are the address (MSB first) and the last 5 are the data (MSB first). Any extra bits sent earlier in a frame are discarded.
- R2: One write occurs per high-to-low transition of `strobe`. Its effect appears on the outputs after the fourth rising `clk` edge following the transition. While `strobe` stays low, further bits shifted in are not written until the next high-to-low transition.
- R3: While `rst_n` is low, the registers take these defaults: address 1 = 01110, 2 = 01110, 3 = 00011, 4 = 10000, 5 = 10111, 6 = 10111, 7 = 01000, 8 = 00000, 9 = 01110, and the test register (address 0) = 00000.
- R4: `pwr_down` neither clears nor blocks anything. Register contents persist through it, and writes made while it is high take effect.
- R5: Writes to address 0 are ignored, so `test_sel` stays 00000. Writes to addresses 10 to 31 change no output.
- R6: The gain outputs are taken from register bits as follows: `gain_a` = address 1 bits 4..1, `gain_b` = address 2 bits 4..1, `gain_c` = address 3 bits 2..0, `gain_d` = address 6 bits 4..3, `gain_e` = address 9 bits 4..1.
- R7: `sw_en` = address 7 bits 3..0, and `par_out` = address 8 bits 3..0.
- R8: Each mute level is 2 bits: 00 = none, 01 = secondary mute, 10 = primary mute. Primary mute takes precedence.
  - Transmit switch i (i = 0..2) sits at `mute_tx[2i+1:2i]`. Its primary bit is address 4 bit 0 and its secondary bit is address 5 bit i.
  - Receive switch i (i = 0..2) sits at `mute_rx[2i+1:2i]`. Its primary bit is address 4 bit 4 and its secondary bit is address 6 bit i.
  - Receive switch 3 sits at `mute_rx[7:6]`. Its primary bit is address 4 bit 4 and its secondary bit is address 5 bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, loads defaults |
| sclk | input | 1 | Serial clock, data sampled on its rising edge |
| sdata | input | 1 | Serial data |
| strobe | input | 1 | Commit strobe, write on its falling edge |
| pwr_down | input | 1 | Power-down indication, no effect on the registers |
| test_sel | output | 5 | Test register contents, always zero |
| gain_a | output | 4 | Gain code from address 1 |
| gain_b | output | 4 | Gain code from address 2 |
| gain_c | output | 3 | Gain code from address 3 |
| gain_d | output | 2 | Gain code from address 6 |
| gain_e | output | 4 | Gain code from address 9 |
| sw_en | output | 4 | Switch enables from address 7 |
| par_out | output | 4 | Parallel output bits from address 8 |
| mute_tx | output | 6 | Mute levels of three transmit switches |
| mute_rx | output | 8 | Mute levels of four receive switches |

## Verification
The shift register takes a bit on the third rising `clk` edge after `sclk` rises. A committed word reaches the outputs on the fourth rising edge after `strobe` falls, counting two synchronizer stages, the edge register and the `ST_COMMIT` cycle. The bench drives its inputs on falling `clk` edges. It applies each write to its behavioural model 1 ns after that fourth rising edge, and it compares every output against the model 2 ns after each rising edge. A change that comes early or late is therefore caught in the cycle it happens. The model is only ever updated after the design's update edge.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 5;
    localparam int FRAME_W  = ADDR_W + DATA_W;
    localparam int NUM_REGS = 10;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_COMMIT = 2'd1,
        ST_HOLD   = 2'd2
    } frame_state_t;

    // Power-on content of each configuration register
    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        logic [DATA_W-1:0] v;
        case (idx)
            1, 2, 9: v = DATA_W'(5'b01110);
            3:       v = DATA_W'(5'b00011);
            4:       v = DATA_W'(5'b10000);
            5, 6:    v = DATA_W'(5'b10111);
            7:       v = DATA_W'(5'b01000);
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
module cfg_sync #(
    parameter int         W   = 3,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST;
            q      <= RST;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/cfg_frame_fsm.sv
`timescale 1ns/1ps
module cfg_frame_fsm
    import cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          sdata_s,
    input  logic          stb_s,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int FW = AW + DW;

    frame_state_t state, state_nx;
    logic         sclk_d, stb_d;
    logic [FW-1:0] shreg;
    logic         sclk_rise, stb_fall;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign stb_fall  = stb_d & ~stb_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            stb_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            stb_d  <= stb_s;
        end
    end

    // Only the newest FW bits survive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else if (sclk_rise)
            shreg <= {shreg[FW-2:0], sdata_s};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HOLD;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARMED:  if (stb_fall) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_HOLD;
            ST_HOLD:   if (stb_s) state_nx = ST_ARMED;
            default:   state_nx = ST_HOLD;
        endcase
    end

    always_comb begin
        wr_en   = (state == ST_COMMIT);
        wr_addr = shreg[FW-1:DW];
        wr_data = shreg[DW-1:0];
    end

    // R2
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank
    import cfg_pkg::*;
#(
    parameter int NR = NUM_REGS,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [NR*DW-1:0] regs_flat
);
    for (genvar g = 0; g < NR; g++) begin : g_reg
        if (g == 0) begin : g_locked
            // test register: writes are refused
            assign regs_flat[g*DW +: DW] = DW'(reg_default(g));
        end else begin : g_rw
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= DW'(reg_default(g));
                else if (wr_en && (wr_addr == AW'(g)))
                    q <= wr_data;
            end
            assign regs_flat[g*DW +: DW] = q;
        end
    end
endmodule

// File: rtl/cfg_decode.sv
`timescale 1ns/1ps
module cfg_decode
    import cfg_pkg::*;
#(
    parameter int NR = NUM_REGS,
    parameter int DW = DATA_W
) (
    input  logic [NR*DW-1:0] regs_flat,
    output logic [4:0]       test_sel,
    output logic [3:0]       gain_a,
    output logic [3:0]       gain_b,
    output logic [2:0]       gain_c,
    output logic [1:0]       gain_d,
    output logic [3:0]       gain_e,
    output logic [3:0]       sw_en,
    output logic [3:0]       par_out,
    output logic [5:0]       mute_tx,
    output logic [7:0]       mute_rx
);
    localparam int TX_SW = 3;
    localparam int RX_SW = 4;

    logic [DW-1:0] r [NR];
    logic          tx_pri, rx_pri;
    logic          unused_bits;

    for (genvar g = 0; g < NR; g++) begin : g_split
        assign r[g] = regs_flat[g*DW +: DW];
    end

    function automatic logic [1:0] level(input logic pri, input logic sec);
        return pri ? 2'b10 : (sec ? 2'b01 : 2'b00);
    endfunction

    assign test_sel = r[0];
    assign gain_a   = r[1][4:1];
    assign gain_b   = r[2][4:1];
    assign gain_c   = r[3][2:0];
    assign gain_d   = r[6][4:3];
    assign gain_e   = r[9][4:1];
    assign sw_en    = r[7][3:0];
    assign par_out  = r[8][3:0];
    assign tx_pri   = r[4][0];
    assign rx_pri   = r[4][4];

    for (genvar i = 0; i < TX_SW; i++) begin : g_tx
        assign mute_tx[2*i +: 2] = level(tx_pri, r[5][i]);
    end

    for (genvar i = 0; i < RX_SW; i++) begin : g_rx
        if (i < 3) begin : g_grp6
            assign mute_rx[2*i +: 2] = level(rx_pri, r[6][i]);
        end else begin : g_grp5
            assign mute_rx[2*i +: 2] = level(rx_pri, r[5][4]);
        end
    end

    assign unused_bits = ^{r[1][0], r[2][0], r[3][4:3], r[4][3:1],
                           r[5][3], r[7][4], r[8][4], r[9][0]};
endmodule

// File: rtl/serial_cfg_bank.sv
`timescale 1ns/1ps
module serial_cfg_bank
    import cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       sdata,
    input  logic       strobe,
    input  logic       pwr_down,
    output logic [4:0] test_sel,
    output logic [3:0] gain_a,
    output logic [3:0] gain_b,
    output logic [2:0] gain_c,
    output logic [1:0] gain_d,
    output logic [3:0] gain_e,
    output logic [3:0] sw_en,
    output logic [3:0] par_out,
    output logic [5:0] mute_tx,
    output logic [7:0] mute_rx
);
    logic [2:0]               sync_q;
    logic                     wr_en;
    logic [ADDR_W-1:0]        wr_addr;
    logic [DATA_W-1:0]        wr_data;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;
    logic                     unused_pwr;

    // power-down has no bearing on storage or writes
    assign unused_pwr = pwr_down;

    cfg_sync #(.W(3), .RST(3'b100)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({strobe, sclk, sdata}),
        .q   (sync_q)
    );

    cfg_frame_fsm #(.AW(ADDR_W), .DW(DATA_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sync_q[1]),
        .sdata_s (sync_q[0]),
        .stb_s   (sync_q[2]),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    cfg_reg_bank #(.NR(NUM_REGS), .AW(ADDR_W), .DW(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .regs_flat (regs_flat)
    );

    cfg_decode #(.NR(NUM_REGS), .DW(DATA_W)) u_dec (
        .regs_flat (regs_flat),
        .test_sel  (test_sel),
        .gain_a    (gain_a),
        .gain_b    (gain_b),
        .gain_c    (gain_c),
        .gain_d    (gain_d),
        .gain_e    (gain_e),
        .sw_en     (sw_en),
        .par_out   (par_out),
        .mute_tx   (mute_tx),
        .mute_rx   (mute_rx)
    );

    // R6
    gain_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == 5'd1) |=> gain_a == $past(wr_data[4:1]));

    // R4
    pwrdn_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down && wr_en && (wr_addr == 5'd9) |=> gain_e == $past(wr_data[4:1]));

    // R5
    unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr >= 5'd10) |=>
        $stable({gain_a, gain_b, gain_c, gain_d, gain_e, sw_en, par_out, mute_tx, mute_rx}));

    // R7
    sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == 5'd7) |=> sw_en == $past(wr_data[3:0]));

    // R8
    mute_prec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == 5'd4) && wr_data[4] |=> mute_rx == 8'b10101010);
endmodule

// File: tb/sim_serial_cfg_bank.sv
`timescale 1ns/1ps
module sim_serial_cfg_bank;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0, sclk = 1'b0, sdata = 1'b0, strobe = 1'b1, pwr_down = 1'b0;
    logic [4:0] test_sel;
    logic [3:0] gain_a, gain_b, gain_e, sw_en, par_out;
    logic [2:0] gain_c;
    logic [1:0] gain_d;
    logic [5:0] mute_tx;
    logic [7:0] mute_rx;

    serial_cfg_bank u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .strobe(strobe),
        .pwr_down(pwr_down), .test_sel(test_sel), .gain_a(gain_a), .gain_b(gain_b),
        .gain_c(gain_c), .gain_d(gain_d), .gain_e(gain_e), .sw_en(sw_en),
        .par_out(par_out), .mute_tx(mute_tx), .mute_rx(mute_rx)
    );

    logic [4:0] mreg [0:9];
    logic [9:0] mshift;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0, run = 0;
    string      phase = "R3 reset";

    task automatic model_reset();
        mreg[0] = 5'b00000; mreg[1] = 5'b01110; mreg[2] = 5'b01110; mreg[3] = 5'b00011;
        mreg[4] = 5'b10000; mreg[5] = 5'b10111; mreg[6] = 5'b10111; mreg[7] = 5'b01000;
        mreg[8] = 5'b00000; mreg[9] = 5'b01110;
        mshift = '0;
    endtask

    function automatic logic [1:0] lvl(input logic p, input logic s);
        if (p) return 2'b10;
        if (s) return 2'b01;
        return 2'b00;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] at %0t: actual %0h expected %0h", tag, phase, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [5:0] etx;
        logic [7:0] erx;
        for (int i = 0; i < 3; i++) etx[2*i +: 2] = lvl(mreg[4][0], mreg[5][i]);
        for (int i = 0; i < 3; i++) erx[2*i +: 2] = lvl(mreg[4][4], mreg[6][i]);
        erx[7:6] = lvl(mreg[4][4], mreg[5][4]);
        chk("R5 test_sel", test_sel, 0);
        chk("R6 gain_a", gain_a, mreg[1][4:1]);
        chk("R6 gain_b", gain_b, mreg[2][4:1]);
        chk("R6 gain_c", gain_c, mreg[3][2:0]);
        chk("R6 gain_d", gain_d, mreg[6][4:3]);
        chk("R6 gain_e", gain_e, mreg[9][4:1]);
        chk("R7 sw_en", sw_en, mreg[7][3:0]);
        chk("R7 par_out", par_out, mreg[8][3:0]);
        chk("R8 mute_tx", mute_tx, etx);
        chk("R8 mute_rx", mute_rx, erx);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (run && !done) compare_all();
        end
    end

    task automatic send_bits(input int n, input logic [31:0] v);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            sdata = v[i];
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            mshift = {mshift[8:0], v[i]};
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic apply_model();
        int a;
        a = int'(mshift[9:5]);
        if (a >= 1 && a <= 9) mreg[a] = mshift[4:0];
    endtask

    task automatic drop_strobe();
        repeat (4) @(negedge clk);
        strobe = 1'b0;
        repeat (4) @(posedge clk);
        #1 apply_model();
    endtask

    task automatic raise_strobe();
        repeat (3) @(negedge clk);
        strobe = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic write(input logic [4:0] a, input logic [4:0] d);
        send_bits(10, {22'd0, a, d});
        drop_strobe();
        raise_strobe();
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog expired: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        model_reset();
        run = 1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        phase = "R6 gains";
        write(5'd1, 5'b10101);
        write(5'd2, 5'b00011);
        write(5'd3, 5'b11101);
        write(5'd6, 5'b01010);
        write(5'd9, 5'b11111);

        phase = "R7 switches";
        write(5'd7, 5'b10110);
        write(5'd8, 5'b01101);

        phase = "R8 mute levels";
        write(5'd4, 5'b00000);
        write(5'd5, 5'b10101);
        write(5'd6, 5'b11011);
        write(5'd4, 5'b00001);
        write(5'd4, 5'b10000);
        write(5'd4, 5'b10001);
        write(5'd5, 5'b00000);
        write(5'd4, 5'b00000);

        phase = "R5 ignored addresses";
        write(5'd0, 5'b11111);
        write(5'd12, 5'b10101);
        write(5'd31, 5'b11111);
        write(5'd10, 5'b00000);

        phase = "R1 extra leading bits";
        send_bits(13, {19'd0, 3'b101, 5'd3, 5'b00101});
        drop_strobe();
        raise_strobe();
        send_bits(7, {25'd0, 7'b1100110});
        send_bits(10, {22'd0, 5'd8, 5'b01010});
        drop_strobe();
        raise_strobe();

        phase = "R2 strobe held low";
        send_bits(10, {22'd0, 5'd1, 5'b00010});
        drop_strobe();
        send_bits(10, {22'd0, 5'd2, 5'b11110});
        repeat (10) @(negedge clk);
        raise_strobe();
        drop_strobe();
        raise_strobe();

        phase = "R4 power-down";
        pwr_down = 1'b1;
        repeat (5) @(negedge clk);
        write(5'd9, 5'b00100);
        write(5'd7, 5'b00011);
        repeat (5) @(negedge clk);
        pwr_down = 1'b0;
        repeat (5) @(negedge clk);

        phase = "R3 mid-run reset";
        @(negedge clk);
        rst_n = 1'b0;
        #1 model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        write(5'd3, 5'b00110);
        repeat (4) @(negedge clk);

        finish_run();
    end
endmodule